// File: doc/BRIEF.md
# UART Modem Control and Status with Internal Loopback

This block is the modem-handshake slice of a 16450-class serial port. It holds the modem control byte that software writes and turns it into four active-low handshake outputs (terminal ready, request to send, and two general-purpose outputs). It samples four active-low handshake inputs (clear to send, data set ready, ring indicator, carrier detect) into a status byte with change flags, and it raises a modem interrupt request while any change flag is set and the interrupt is enabled.

A self-test mode is selected by one control bit. In that mode the serial path and the handshake path stay inside the chip. The transmitter's serial output feeds the receiver directly, and the four status inputs are taken from the low control bits. The external pins are cut off: the TX pin idles at mark and the handshake outputs sit inactive. Change detection and the interrupt request behave exactly as they do in normal mode, so software can exercise its whole modem-interrupt path without a cable.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00. A write stores bit 0 (DTR), bit 1 (RTS), bit 2 (OUT1), bit 3 (OUT2) and bit 4 (loopback select), and bits 7..5 always read as zero.
- R2: Outside loopback each handshake output pin is the inverse of its control bit: `dtr_n`=~bit0, `rts_n`=~bit1, `out1_n`=~bit2, `out2_n`=~bit3.
- R3: Outside loopback the status byte's upper nibble reports, from bit 7 down, CD, RI, DSR and CTS as the inverted pin levels, no later than three clock edges after a pin changes.
- R4: The change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) set on either edge of the corresponding status bit.
- R5: The RI change flag (bit 2) sets only when RI status goes from 1 to 0; a 0-to-1 transition leaves it clear.
- R6: A status read strobe clears all four change flags, except a flag whose status changes in the same clock edge, which stays set.
- R7: `modem_irq` is high exactly while `msr_int_en` is high and at least one change flag is set.
- R8: In loopback `core_rx` follows `core_tx`, `tx_pin` is held at 1, and `rx_pin` has no effect.
- R9: In loopback all four handshake output pins are held at 1 regardless of the control bits.
- R10: In loopback the status byte takes CTS from bit 0, DSR from bit 1, RI from bit 2 and CD from bit 3 of the control byte, and the external handshake pins have no effect.
- R11: Change flags and the interrupt request of R4 to R7 operate in loopback on the rerouted status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mcr_we | input | 1 | Write strobe for the control byte |
| mcr_wdata | input | 8 | Value written to the control byte |
| mcr_rdata | output | 8 | Current control byte |
| msr_rd | input | 1 | Read strobe for the status byte; clears change flags |
| msr_int_en | input | 1 | Modem-status interrupt enable |
| msr_rdata | output | 8 | Status byte: levels in 7..4, change flags in 3..0 |
| modem_irq | output | 1 | Modem-status interrupt request |
| cts_pin_n | input | 1 | Clear-to-send pin, active low |
| dsr_pin_n | input | 1 | Data-set-ready pin, active low |
| ri_pin_n | input | 1 | Ring-indicator pin, active low |
| cd_pin_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| core_tx | input | 1 | Serial output of the transmitter |
| tx_pin | output | 1 | Serial TX pin |
| rx_pin | input | 1 | Serial RX pin |
| core_rx | output | 1 | Serial input to the receiver |

## Verification
The properties assume the read strobe and control writes are single-cycle pulses driven from synchronous logic, while the handshake pins may change at any time and are only trusted after synchronization. The flag properties also assume that when status is stable across a read, no other event can re-set a flag, which holds because only status transitions set flags. The stimulus changes pins and strobes on the falling clock edge, spaces pin changes at least four cycles apart so each lands in the status byte before the next, and deliberately aligns one status change with a read edge to hit the clear-versus-set race.

// File: rtl/uart_modem_pkg.sv
// Shared definitions for the modem control/status slice.
// Assumes: control byte bit layout is fixed by software convention.
package uart_modem_pkg;

    localparam int MCR_W       = 8;
    localparam int MCR_DTR     = 0;
    localparam int MCR_RTS     = 1;
    localparam int MCR_OUT1    = 2;
    localparam int MCR_OUT2    = 3;
    localparam int MCR_LOOP    = 4;
    localparam logic [MCR_W-1:0] MCR_MASK = 8'h1F;

    // Status nibble, ordered as it appears in the status byte (bit 7 first).
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_stat_t;

    localparam int STAT_W = $bits(modem_stat_t);

endpackage

// File: rtl/modem_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous level inputs.
// Assumes: each bit is an independent level; no cross-bit coherence needed.
module modem_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop rank of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= {WIDTH{RESET_VAL}};
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/modem_loop_route.sv
// Combinational routing between normal and self-test (loopback) paths.
// Assumes: sync_pins_n are already synchronized, active low.
module modem_loop_route
    import uart_modem_pkg::*;
(
    input  logic              loop_en,
    input  logic [3:0]        mcr_ctl,     // {out2, out1, rts, dtr}
    input  logic [STAT_W-1:0] sync_pins_n, // {cd, ri, dsr, cts}, active low
    input  logic              core_tx,
    input  logic              rx_pin,
    output modem_stat_t       stat_src,
    output logic [3:0]        pins_n,      // {out2_n, out1_n, rts_n, dtr_n}
    output logic              tx_pin,
    output logic              core_rx
);

    // Select the status source: pins in normal mode, control bits in loopback.
    always_comb begin
        if (loop_en) begin
            stat_src.cts = mcr_ctl[MCR_DTR];
            stat_src.dsr = mcr_ctl[MCR_RTS];
            stat_src.ri  = mcr_ctl[MCR_OUT1];
            stat_src.cd  = mcr_ctl[MCR_OUT2];
        end else begin
            stat_src = modem_stat_t'(~sync_pins_n);
        end
    end

    // Drive pins: inverted control in normal mode, inactive in loopback.
    always_comb begin
        pins_n  = loop_en ? 4'hF : ~mcr_ctl;
        tx_pin  = loop_en ? 1'b1 : core_tx;
        core_rx = loop_en ? core_tx : rx_pin;
    end

endmodule

// File: rtl/modem_delta.sv
// Status register with change flags and interrupt request.
// Assumes: stat_src is synchronous; rd_clr is a single-cycle strobe.
module modem_delta
    import uart_modem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  modem_stat_t stat_src,
    input  logic        rd_clr,
    input  logic        int_en,
    output modem_stat_t stat_q,
    output modem_stat_t delta_q,
    output logic        irq
);

    modem_stat_t set_now;

    // Work out which flags the upcoming edge sets.
    always_comb begin
        set_now.cts = stat_src.cts ^ stat_q.cts;
        set_now.dsr = stat_src.dsr ^ stat_q.dsr;
        set_now.cd  = stat_src.cd  ^ stat_q.cd;
        set_now.ri  = stat_q.ri & ~stat_src.ri;
    end

    // Register status and accumulate change flags; a read clears, a new change wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            delta_q <= '0;
        end else begin
            stat_q  <= stat_src;
            delta_q <= (rd_clr ? modem_stat_t'('0) : delta_q) | set_now;
        end
    end

    assign irq = int_en & (|delta_q);

endmodule

// File: rtl/uart_modem_ctrl.sv
// Top of the modem control/status slice with internal loopback.
// Assumes: bus strobes are synchronous to clk; modem pins are asynchronous.
module uart_modem_ctrl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mcr_we,
    input  logic [7:0] mcr_wdata,
    output logic [7:0] mcr_rdata,
    input  logic       msr_rd,
    input  logic       msr_int_en,
    output logic [7:0] msr_rdata,
    output logic       modem_irq,
    input  logic       cts_pin_n,
    input  logic       dsr_pin_n,
    input  logic       ri_pin_n,
    input  logic       cd_pin_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    input  logic       core_tx,
    output logic       tx_pin,
    input  logic       rx_pin,
    output logic       core_rx
);

    logic [MCR_W-1:0]  mcr_q;
    logic [STAT_W-1:0] pins_sync_n;
    logic [3:0]        pins_n;
    modem_stat_t       stat_src;
    modem_stat_t       stat_q;
    modem_stat_t       delta_q;

    // Control byte register; unused upper bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcr_q <= '0;
        end else if (mcr_we) begin
            mcr_q <= mcr_wdata & MCR_MASK;
        end
    end

    modem_sync #(
        .WIDTH     (STAT_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cd_pin_n, ri_pin_n, dsr_pin_n, cts_pin_n}),
        .sync_out (pins_sync_n)
    );

    modem_loop_route u_route (
        .loop_en     (mcr_q[MCR_LOOP]),
        .mcr_ctl     (mcr_q[3:0]),
        .sync_pins_n (pins_sync_n),
        .core_tx     (core_tx),
        .rx_pin      (rx_pin),
        .stat_src    (stat_src),
        .pins_n      (pins_n),
        .tx_pin      (tx_pin),
        .core_rx     (core_rx)
    );

    modem_delta u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_src (stat_src),
        .rd_clr   (msr_rd),
        .int_en   (msr_int_en),
        .stat_q   (stat_q),
        .delta_q  (delta_q),
        .irq      (modem_irq)
    );

    assign mcr_rdata = mcr_q;
    assign msr_rdata = {stat_q, delta_q};
    assign dtr_n     = pins_n[MCR_DTR];
    assign rts_n     = pins_n[MCR_RTS];
    assign out1_n    = pins_n[MCR_OUT1];
    assign out2_n    = pins_n[MCR_OUT2];

endmodule

// File: rtl/uart_modem_ctrl_chk.sv
// Property checker for uart_modem_ctrl, attached by bind.
// Assumes: observes only top-level ports.
module uart_modem_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mcr_rdata,
    input logic       msr_rd,
    input logic       msr_int_en,
    input logic [7:0] msr_rdata,
    input logic       modem_irq,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n,
    input logic       core_tx,
    input logic       tx_pin,
    input logic       core_rx
);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[7:5] == 3'b000);

    assert_pins_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_rdata[4] |-> ({out2_n, out1_n, rts_n, dtr_n} == ~mcr_rdata[3:0]));

    assert_ri_rise_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msr_rdata[6]) && !$past(msr_rdata[2])) |-> !msr_rdata[2]);

    assert_ri_fall_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msr_rdata[6]) |-> msr_rdata[2]);

    assert_cts_edge_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(msr_rdata[4]) |-> msr_rdata[0]);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        msr_rd |=> ($stable(msr_rdata[7:4]) -> (msr_rdata[3:0] == 4'h0)));

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_int_en |-> !modem_irq);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        modem_irq |-> (msr_rdata[3:0] != 4'h0));

    assert_loop_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> (tx_pin && (core_rx == core_tx)));

    assert_loop_pins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> ({out2_n, out1_n, rts_n, dtr_n} == 4'hF));

    assert_loop_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_rdata[4] && $past(mcr_rdata[4])) |-> (msr_rdata[7:4] == $past(mcr_rdata[3:0])));

endmodule

bind uart_modem_ctrl uart_modem_ctrl_chk u_chk (.*);

// File: tb/uart_modem_ctrl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mcr_we;
    logic [7:0] mcr_wdata;
    logic [7:0] mcr_rdata;
    logic       msr_rd;
    logic       msr_int_en;
    logic [7:0] msr_rdata;
    logic       modem_irq;
    logic       cts_pin_n, dsr_pin_n, ri_pin_n, cd_pin_n;
    logic       dtr_n, rts_n, out1_n, out2_n;
    logic       core_tx, tx_pin, rx_pin, core_rx;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    uart_modem_ctrl u_uart_modem_ctrl (
        .clk(clk), .rst_n(rst_n), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
        .mcr_rdata(mcr_rdata), .msr_rd(msr_rd), .msr_int_en(msr_int_en),
        .msr_rdata(msr_rdata), .modem_irq(modem_irq),
        .cts_pin_n(cts_pin_n), .dsr_pin_n(dsr_pin_n), .ri_pin_n(ri_pin_n),
        .cd_pin_n(cd_pin_n), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
        .out2_n(out2_n), .core_tx(core_tx), .tx_pin(tx_pin), .rx_pin(rx_pin),
        .core_rx(core_rx)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mcr(input logic [7:0] v);
        mcr_we = 1'b1; mcr_wdata = v;
        tick(1);
        mcr_we = 1'b0;
        tick(1);
    endtask

    task automatic read_msr();
        msr_rd = 1'b1;
        tick(1);
        msr_rd = 1'b0;
    endtask

    function automatic logic [7:0] pins4();
        return {4'h0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    task automatic t_reset();
        check("R1 reset mcr", mcr_rdata, 8'h00);
        check("R3 reset msr", msr_rdata, 8'h00);
        check("R2 reset pins", pins4(), 8'h0F);
        check("R7 reset irq", {7'h0, modem_irq}, 8'h00);
    endtask

    task automatic t_mcr_bits();
        write_mcr(8'hEF);
        check("R1 upper bits zero", mcr_rdata, 8'h0F);
        check("R2 all asserted", pins4(), 8'h00);
        write_mcr(8'h05);
        check("R2 pattern 05", pins4(), 8'h0A);
        check("R8 tx passes normal", {7'h0, tx_pin}, {7'h0, core_tx});
        rx_pin = 1'b0; tick(1);
        check("R8 rx passes normal", {7'h0, core_rx}, 8'h00);
        rx_pin = 1'b1;
        write_mcr(8'h00);
    endtask

    task automatic t_status_edges();
        msr_int_en = 1'b1;
        cts_pin_n = 1'b0; tick(4);
        check("R3 R4 cts assert", msr_rdata, 8'h11);
        check("R7 irq on", {7'h0, modem_irq}, 8'h01);
        read_msr(); tick(1);
        check("R6 read clears", msr_rdata, 8'h10);
        check("R7 irq off", {7'h0, modem_irq}, 8'h00);
        cts_pin_n = 1'b1; tick(4);
        check("R4 cts release", msr_rdata, 8'h01);
        read_msr();
        dsr_pin_n = 1'b0; tick(4);
        check("R4 dsr assert", msr_rdata, 8'h22);
        read_msr();
        cd_pin_n = 1'b0; tick(4);
        check("R4 cd assert", msr_rdata, 8'hA8);
        read_msr();
        cd_pin_n = 1'b1; dsr_pin_n = 1'b1; tick(4);
        check("R4 cd dsr release", msr_rdata, 8'h0A);
        read_msr(); tick(1);
        ri_pin_n = 1'b0; tick(4);
        check("R5 ri rise no flag", msr_rdata, 8'h40);
        check("R7 no irq", {7'h0, modem_irq}, 8'h00);
        ri_pin_n = 1'b1; tick(4);
        check("R5 ri fall flag", msr_rdata, 8'h04);
        msr_int_en = 1'b0; tick(1);
        check("R7 gated", {7'h0, modem_irq}, 8'h00);
        msr_int_en = 1'b1; tick(1);
        check("R7 enabled", {7'h0, modem_irq}, 8'h01);
        read_msr();
    endtask

    task automatic t_read_race();
        dsr_pin_n = 1'b0; tick(4);
        cts_pin_n = 1'b0;          // reaches status at the third edge
        tick(2);
        msr_rd = 1'b1;             // read strobe on that same edge
        tick(1);
        msr_rd = 1'b0;
        check("R6 same-edge change kept", msr_rdata, 8'h31);
        read_msr();
        cts_pin_n = 1'b1; dsr_pin_n = 1'b1; tick(4);
        read_msr(); tick(1);
        check("R6 cleared again", msr_rdata, 8'h00);
    endtask

    task automatic t_loopback();
        write_mcr(8'h10);
        read_msr(); tick(1);
        check("R10 loop idle status", msr_rdata, 8'h00);
        check("R9 pins idle", pins4(), 8'h0F);
        core_tx = 1'b0; rx_pin = 1'b1; tick(1);
        check("R8 tx pin held", {7'h0, tx_pin}, 8'h01);
        check("R8 rx from tx low", {7'h0, core_rx}, 8'h00);
        core_tx = 1'b1; rx_pin = 1'b0; tick(1);
        check("R8 rx from tx high", {7'h0, core_rx}, 8'h01);
        rx_pin = 1'b1;
        write_mcr(8'h1F);
        check("R9 pins stay idle", pins4(), 8'h0F);
        check("R10 R11 all from mcr", msr_rdata, 8'hFB);
        check("R11 irq in loop", {7'h0, modem_irq}, 8'h01);
        read_msr(); tick(1);
        cts_pin_n = 1'b0; dsr_pin_n = 1'b0; ri_pin_n = 1'b0; cd_pin_n = 1'b0;
        tick(5);
        check("R10 pins ignored", msr_rdata, 8'hF0);
        cts_pin_n = 1'b1; dsr_pin_n = 1'b1; ri_pin_n = 1'b1; cd_pin_n = 1'b1;
        tick(5);
        write_mcr(8'h1B);
        check("R11 ri fall in loop", msr_rdata, 8'hB4);
        read_msr();
        write_mcr(8'h11);
        check("R10 dtr to cts only", msr_rdata, 8'h1A);
        read_msr();
        write_mcr(8'h00);
        tick(4);
        read_msr(); tick(1);
        check("R2 exit loop pins", pins4(), 8'h0F);
        check("R3 exit loop status", msr_rdata, 8'h00);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mcr_we = 1'b0; mcr_wdata = 8'h00; msr_rd = 1'b0;
        msr_int_en = 1'b0; cts_pin_n = 1'b1; dsr_pin_n = 1'b1;
        ri_pin_n = 1'b1; cd_pin_n = 1'b1; core_tx = 1'b1; rx_pin = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_mcr_bits();
        t_status_edges();
        t_read_race();
        t_loopback();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule